// File: doc/BRIEF.md
# Channel Transfer Sequencer

This block steps one transfer channel through a block made of frames, each frame made of elements. Each cycle in which the channel is active it moves exactly one element. It drives a transfer strobe, a write enable and the write data, and it advances the destination address. A host programs the counts, the address steps and the mode bits. The host then pulses `start`. Peripheral requests arrive on `req`, and any status the host has unmasked stays visible in a sticky status word.

A channel with synchronisation turned on pauses at a granularity chosen by two mode bits: after every element, after every frame, or after every packet. A request that arrives while the channel is active is held as pending. A second such request is dropped and reported. When the block finishes, the chosen mode decides what happens next. The channel can stop and hand over to a linked channel. It can stop outright. It can reload itself and keep running. Or it can park until the host pulses `resume`. On the data path the write data can come from a fixed colour register instead of the read data. A transparent mode suppresses the write of any element that equals the colour.

Top module: `xfer_seq`

## Requirements
- R1: After reset the channel is disabled and inactive, and `status` and `cpc` are 0. A `start` pulse with nonzero element and frame counts enables the channel. With `cfg_sync`=0 it is then active from the next cycle and transfers one element per cycle until the block completes. A `start` with a zero count is ignored.
- R2: Status bits are: 0 timeout, 1 dropped request, 2 half frame, 3 frame end, 4 last frame, 5 block end, 6 sync active, 7 packet end, 8 transfer error, 11 misalignment. A bit is set only when the same bit of `irq_mask` is 1. Bits other than 6 stay set until a `stat_clr` pulse clears them.
- R3: Bit 2 sets when the element count within a frame reaches `cfg_elems>>1`. Bit 4 sets after the first element of the final frame. Bit 3 sets at every frame end. Bit 5 sets at block end.
- R4: A synchronised channel with `cfg_fs`=0 and `cfg_bs`=0 moves exactly one element per `req` pulse.
- R5: With `cfg_fs`=1 and `cfg_bs`=0, a synchronised channel pauses after each frame. A `req` that arrives while the channel is active is held, and the held request continues the channel at the next pause. A further `req` that arrives while one is already held sets bit 1.
- R6: With `cfg_fs`=1 and `cfg_bs`=1, elements are counted in packets of `cfg_pkt`. A synchronised channel pauses at each packet end. Bit 7 is set at a packet end only when `cfg_src_sync`=0.
- R7: For an unsynchronised channel, `cpc` takes the low 16 bits of the destination address at each frame end. The captured address is the one after that frame's element and frame steps.
- R8: With `cfg_chain_mode`=1, block end disables the channel. If `cfg_link_en`=1, it also raises `link_stb` for one cycle, carrying `cfg_link_ch` on `link_ch`, in the same cycle that `ch_enabled` falls.
- R9: With `cfg_chain_mode`=0, block end behaves according to the other mode bits. With `cfg_autoinit`=0 it disables the channel. With `cfg_autoinit`=1 and either `cfg_repeat` or `cfg_endprog` set, the channel reloads and keeps running. With `cfg_autoinit` alone it stays enabled but inactive until a `resume` pulse restarts the block.
- R10: With `cfg_const_fill`=1, `wr_data` is `cfg_color`. With `cfg_transp`=1, `wr_en` is 0 for any element whose data equals `cfg_color`, while `xfer_stb` is still 1.
- R11: Bit 6 reads 1 while a synchronised channel is active, provided `irq_mask[6]`=1. It reads 0 once the channel pauses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | enable pulse, loads the block |
| resume | input | 1 | restarts a parked channel |
| req | input | 1 | peripheral request pulse |
| stat_clr | input | 1 | clears sticky status |
| cfg_elems | input | EW | elements per frame |
| cfg_frames | input | FW | frames per block |
| cfg_pkt | input | EW | elements per packet |
| cfg_sync | input | 1 | channel is request-synchronised |
| cfg_fs | input | 1 | frame granularity bit |
| cfg_bs | input | 1 | packet granularity bit (with cfg_fs) |
| cfg_src_sync | input | 1 | requests come from the source side |
| cfg_chain_mode | input | 1 | block end disables and may link |
| cfg_autoinit | input | 1 | reload or park at block end |
| cfg_repeat | input | 1 | reload continuously |
| cfg_endprog | input | 1 | reprogramming done, reload |
| cfg_link_en | input | 1 | hand over to linked channel |
| cfg_link_ch | input | LW | linked channel number |
| cfg_const_fill | input | 1 | data source is the colour |
| cfg_transp | input | 1 | skip writes equal to the colour |
| cfg_color | input | DW | colour value |
| cfg_dst_base | input | AW | destination start address |
| cfg_estep | input | AW | address step per element |
| cfg_fstep | input | AW | extra address step per frame |
| irq_mask | input | SW | status enable mask |
| rd_data | input | DW | data read from source |
| xfer_stb | output | 1 | one element moves this cycle |
| wr_en | output | 1 | write this element |
| wr_data | output | DW | data to write |
| dst_addr | output | AW | current destination address |
| cpc | output | 16 | current position |
| status | output | SW | status word |
| ch_enabled | output | 1 | channel enabled |
| ch_active | output | 1 | channel transferring |
| link_stb | output | 1 | linked channel enable pulse |
| link_ch | output | LW | linked channel number |

## Verification
`xfer_stb`, `wr_en` and `wr_data` follow the active state with no register in between, so they are due in the half cycle after the edge that activates the channel. The bench reads them at the next falling edge. Status bits, `cpc`, `link_stb` and the drop of `ch_enabled` are registered. They show at the falling edge after the transfer that causes them. This is why transfers are counted at every falling edge until the channel goes idle, and the status word and position are read only after that. Request-driven cases apply a `req` pulse across one rising edge and then count the transfers over a fixed window, so that a pause is seen as a stop in the count.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
   // status bit positions decoded by host software
   localparam int ST_TIMEOUT = 0;
   localparam int ST_DROP    = 1;
   localparam int ST_HALF    = 2;
   localparam int ST_FEND    = 3;
   localparam int ST_LFRAME  = 4;
   localparam int ST_BEND    = 5;
   localparam int ST_SYNC    = 6;
   localparam int ST_PEND    = 7;
   localparam int ST_TERR    = 8;
   localparam int ST_MISAL   = 11;
   localparam int ST_MIN_W   = 12;
endpackage

// File: rtl/xfer_seq_cnt.sv
module xfer_seq_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] lim,
   output logic [W-1:0] cnt,
   output logic [W-1:0] nxt,
   output logic         wrap
);
   assign nxt  = cnt + W'(1);
   assign wrap = (nxt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= wrap ? '0 : nxt;
   end
endmodule

// File: rtl/xfer_seq_stat.sv
module xfer_seq_stat
   import xfer_seq_pkg::*;
#(
   parameter int SW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [SW-1:0] ev,
   input  logic [SW-1:0] mask,
   input  logic          sync_live,
   output logic [SW-1:0] word
);
   logic [SW-1:0] sticky_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= (sticky_q & ~{SW{clr}}) | (ev & mask);
   end

   always_comb begin
      word          = sticky_q;
      word[ST_SYNC] = sync_live & mask[ST_SYNC];
   end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
   import xfer_seq_pkg::*;
#(
   parameter int EW = 8,
   parameter int FW = 8,
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int LW = 4,
   parameter int SW = 16,
   parameter bit FILL_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          resume,
   input  logic          req,
   input  logic          stat_clr,
   input  logic [EW-1:0] cfg_elems,
   input  logic [FW-1:0] cfg_frames,
   input  logic [EW-1:0] cfg_pkt,
   input  logic          cfg_sync,
   input  logic          cfg_fs,
   input  logic          cfg_bs,
   input  logic          cfg_src_sync,
   input  logic          cfg_chain_mode,
   input  logic          cfg_autoinit,
   input  logic          cfg_repeat,
   input  logic          cfg_endprog,
   input  logic          cfg_link_en,
   input  logic [LW-1:0] cfg_link_ch,
   input  logic          cfg_const_fill,
   input  logic          cfg_transp,
   input  logic [DW-1:0] cfg_color,
   input  logic [AW-1:0] cfg_dst_base,
   input  logic [AW-1:0] cfg_estep,
   input  logic [AW-1:0] cfg_fstep,
   input  logic [SW-1:0] irq_mask,
   input  logic [DW-1:0] rd_data,
   output logic          xfer_stb,
   output logic          wr_en,
   output logic [DW-1:0] wr_data,
   output logic [AW-1:0] dst_addr,
   output logic [15:0]   cpc,
   output logic [SW-1:0] status,
   output logic          ch_enabled,
   output logic          ch_active,
   output logic          link_stb,
   output logic [LW-1:0] link_ch
);
   localparam int CPC_W = 16;

   if (SW < ST_MIN_W) begin : g_sw_bad
      $error("xfer_seq: SW too small for status layout");
   end
   if (AW < CPC_W) begin : g_aw_bad
      $error("xfer_seq: AW narrower than position field");
   end

   logic          en_q, act_q, pend_q, park_q;
   logic [AW-1:0] addr_q;
   logic [CPC_W-1:0] cpc_q;
   logic          lnk_q;
   logic [LW-1:0] lnk_ch_q;

   logic [EW-1:0] e_cnt, e_nxt, p_cnt, p_nxt;
   logic [FW-1:0] f_cnt, f_nxt;
   logic          e_wrap, f_wrap, p_wrap;

   logic xfer, blk_end, pkt_end, pause, req_hit, pend_eff, drop;
   logic start_ok, resume_ok, kill, reload_blk, park, load;
   logic [AW-1:0] addr_nxt;
   logic [SW-1:0] ev;

   assign xfer      = act_q;
   assign start_ok  = start & ~en_q & (cfg_elems != '0) & (cfg_frames != '0);
   assign resume_ok = resume & park_q & en_q;
   assign blk_end   = xfer & e_wrap & f_wrap;
   assign pkt_end   = xfer & cfg_fs & cfg_bs & p_wrap;
   assign pause     = cfg_sync & xfer &
                      ((~cfg_fs & ~cfg_bs) | (cfg_fs & ~cfg_bs & e_wrap) | pkt_end);
   assign req_hit   = req & en_q;
   assign pend_eff  = pend_q | (req_hit & act_q);
   assign drop      = req_hit & act_q & pend_q;

   assign kill       = blk_end & (cfg_chain_mode | ~cfg_autoinit);
   assign reload_blk = blk_end & ~cfg_chain_mode & cfg_autoinit & (cfg_repeat | cfg_endprog);
   assign park       = blk_end & ~cfg_chain_mode & cfg_autoinit & ~cfg_repeat & ~cfg_endprog;
   assign load       = start_ok | resume_ok | reload_blk;

   xfer_seq_cnt #(.W(EW)) elem_cnt_i (
      .clk(clk), .rst_n(rst_n), .clr(load), .inc(xfer), .lim(cfg_elems),
      .cnt(e_cnt), .nxt(e_nxt), .wrap(e_wrap));
   xfer_seq_cnt #(.W(FW)) frame_cnt_i (
      .clk(clk), .rst_n(rst_n), .clr(load), .inc(xfer & e_wrap), .lim(cfg_frames),
      .cnt(f_cnt), .nxt(f_nxt), .wrap(f_wrap));
   xfer_seq_cnt #(.W(EW)) pkt_cnt_i (
      .clk(clk), .rst_n(rst_n), .clr(load), .inc(xfer & cfg_fs & cfg_bs), .lim(cfg_pkt),
      .cnt(p_cnt), .nxt(p_nxt), .wrap(p_wrap));

   // channel control state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         act_q  <= 1'b0;
         pend_q <= 1'b0;
         park_q <= 1'b0;
      end else if (start_ok) begin
         en_q   <= 1'b1;
         act_q  <= ~cfg_sync | req;
         pend_q <= 1'b0;
         park_q <= 1'b0;
      end else if (kill) begin
         en_q   <= 1'b0;
         act_q  <= 1'b0;
         pend_q <= 1'b0;
         park_q <= 1'b0;
      end else if (park) begin
         act_q  <= 1'b0;
         pend_q <= pend_eff;
         park_q <= 1'b1;
      end else if (pause) begin
         act_q  <= pend_eff;
         pend_q <= 1'b0;
      end else if (resume_ok) begin
         act_q  <= ~cfg_sync | pend_q | req;
         pend_q <= 1'b0;
         park_q <= 1'b0;
      end else if (req_hit & ~act_q & ~park_q) begin
         act_q  <= 1'b1;
      end else if (req_hit) begin
         pend_q <= 1'b1;
      end
   end

   // destination address and position
   assign addr_nxt = addr_q + cfg_estep + (e_wrap ? cfg_fstep : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cpc_q  <= '0;
      end else begin
         if (load)      addr_q <= cfg_dst_base;
         else if (xfer) addr_q <= addr_nxt;
         if (xfer & e_wrap & ~cfg_sync) cpc_q <= addr_nxt[CPC_W-1:0];
      end
   end

   // hand-over pulse to the linked channel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lnk_q    <= 1'b0;
         lnk_ch_q <= '0;
      end else begin
         lnk_q <= blk_end & cfg_chain_mode & cfg_link_en;
         if (blk_end) lnk_ch_q <= cfg_link_ch;
      end
   end

   // status events
   always_comb begin
      ev            = '0;
      ev[ST_DROP]   = drop;
      ev[ST_HALF]   = xfer & (e_nxt == (cfg_elems >> 1));
      ev[ST_FEND]   = xfer & e_wrap;
      ev[ST_LFRAME] = xfer & (e_nxt == EW'(1)) & f_wrap;
      ev[ST_BEND]   = blk_end;
      ev[ST_PEND]   = pkt_end & ~cfg_src_sync;
   end

   xfer_seq_stat #(.SW(SW)) stat_i (
      .clk(clk), .rst_n(rst_n), .clr(stat_clr), .ev(ev), .mask(irq_mask),
      .sync_live(act_q & cfg_sync), .word(status));

   // data path variant
   if (FILL_EN) begin : g_fill
      logic [DW-1:0] src;
      assign src     = cfg_const_fill ? cfg_color : rd_data;
      assign wr_data = src;
      assign wr_en   = xfer & ~(cfg_transp & (src == cfg_color));
   end else begin : g_plain
      assign wr_data = rd_data;
      assign wr_en   = xfer;
   end

   assign xfer_stb   = xfer;
   assign dst_addr   = addr_q;
   assign cpc        = cpc_q;
   assign ch_enabled = en_q;
   assign ch_active  = act_q;
   assign link_stb   = lnk_q;
   assign link_ch    = lnk_ch_q;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk
   import xfer_seq_pkg::*;
#(
   parameter int SW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          xfer_stb,
   input logic          wr_en,
   input logic          ch_active,
   input logic          ch_enabled,
   input logic          link_stb,
   input logic          cfg_sync,
   input logic [15:0]   cpc,
   input logic [SW-1:0] status,
   input logic [SW-1:0] irq_mask
);
   // R1
   active_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_active |-> ch_enabled);

   // R10
   write_needs_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> xfer_stb);

   // R8
   link_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_stb |-> !ch_enabled);

   // R2
   half_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_HALF]) |-> $past(irq_mask[ST_HALF]));

   // R3
   bend_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[ST_BEND]) |-> $past(xfer_stb));

   // R7
   cpc_unsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cpc) |-> $past(xfer_stb && !cfg_sync));
endmodule

bind xfer_seq xfer_seq_chk #(.SW(SW)) chk_i (
   .clk(clk), .rst_n(rst_n), .xfer_stb(xfer_stb), .wr_en(wr_en),
   .ch_active(ch_active), .ch_enabled(ch_enabled), .link_stb(link_stb),
   .cfg_sync(cfg_sync), .cpc(cpc), .status(status), .irq_mask(irq_mask));

// File: tb/xfer_seq_tb_top.sv
module xfer_seq_tb_top;
   localparam int CLK_PER = 10;
   localparam int NV = 4;
   localparam int V_E [NV] = '{1, 4, 5, 3};
   localparam int V_F [NV] = '{1, 3, 2, 4};
   localparam int V_ES[NV] = '{4, 1, 2, 8};
   localparam int V_FS[NV] = '{0, 16, 3, 5};
   localparam logic [31:0] BASE = 32'h0001_F000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 0, resume = 0, req = 0, stat_clr = 0;
   logic [7:0] cfg_elems = 0, cfg_pkt = 0;
   logic [7:0] cfg_frames = 0;
   logic cfg_sync = 0, cfg_fs = 0, cfg_bs = 0, cfg_src_sync = 0, cfg_chain_mode = 0;
   logic cfg_autoinit = 0, cfg_repeat = 0, cfg_endprog = 0, cfg_link_en = 0;
   logic [3:0] cfg_link_ch = 0;
   logic cfg_const_fill = 0, cfg_transp = 0;
   logic [31:0] cfg_color = 0, cfg_dst_base = 0, cfg_estep = 0, cfg_fstep = 0, rd_data = 0;
   logic [15:0] irq_mask = 16'hFFFF;
   logic xfer_stb, wr_en, ch_enabled, ch_active, link_stb;
   logic [31:0] wr_data, dst_addr;
   logic [15:0] cpc, status;
   logic [3:0] link_ch;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PER/2) clk = ~clk;

   xfer_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .req(req),
      .stat_clr(stat_clr), .cfg_elems(cfg_elems), .cfg_frames(cfg_frames),
      .cfg_pkt(cfg_pkt), .cfg_sync(cfg_sync), .cfg_fs(cfg_fs), .cfg_bs(cfg_bs),
      .cfg_src_sync(cfg_src_sync), .cfg_chain_mode(cfg_chain_mode),
      .cfg_autoinit(cfg_autoinit), .cfg_repeat(cfg_repeat), .cfg_endprog(cfg_endprog),
      .cfg_link_en(cfg_link_en), .cfg_link_ch(cfg_link_ch),
      .cfg_const_fill(cfg_const_fill), .cfg_transp(cfg_transp), .cfg_color(cfg_color),
      .cfg_dst_base(cfg_dst_base), .cfg_estep(cfg_estep), .cfg_fstep(cfg_fstep),
      .irq_mask(irq_mask), .rd_data(rd_data), .xfer_stb(xfer_stb), .wr_en(wr_en),
      .wr_data(wr_data), .dst_addr(dst_addr), .cpc(cpc), .status(status),
      .ch_enabled(ch_enabled), .ch_active(ch_active), .link_stb(link_stb),
      .link_ch(link_ch));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic pulse_req();
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic clear_stat();
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
   endtask

   task automatic run_idle(output int n);
      n = 0;
      for (int i = 0; i < 400; i++) begin
         if (!ch_enabled && !ch_active) break;
         if (xfer_stb) n++;
         @(negedge clk);
      end
   endtask

   task automatic count_for(input int k, output int n);
      n = 0;
      for (int i = 0; i < k; i++) begin
         if (xfer_stb) n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int n, m;
      logic [31:0] exp_cpc, exp_st;
      bit seen;
      logic [3:0] lc;
      logic en_at;
      repeat (3) @(negedge clk);
      // R1 R2 reset state
      check("R1 reset enabled", ch_enabled, 0);
      check("R1 reset active", ch_active, 0);
      check("R2 reset status", status, 0);
      check("R7 reset cpc", cpc, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: unsynchronised, self-disabling blocks
      cfg_chain_mode = 1'b1;
      cfg_dst_base   = BASE;
      for (int v = 0; v < NV; v++) begin
         cfg_elems  = 8'(V_E[v]);
         cfg_frames = 8'(V_F[v]);
         cfg_estep  = 32'(V_ES[v]);
         cfg_fstep  = 32'(V_FS[v]);
         clear_stat();
         pulse_start();
         run_idle(n);
         exp_cpc = BASE + 32'(V_F[v] * (V_E[v] * V_ES[v] + V_FS[v]));
         exp_st  = 32'h38 | ((V_E[v] >= 2) ? 32'h4 : 32'h0);
         check("R1 element count", n, V_E[v] * V_F[v]);
         check("R3 status events", {16'h0, status}, exp_st);
         check("R7 position", {16'h0, cpc}, {16'h0, exp_cpc[15:0]});
      end

      // R1 zero count ignored
      cfg_elems = 0;
      pulse_start();
      check("R1 zero count start", ch_enabled, 0);

      // R2 mask blocks status, stat_clr clears
      cfg_elems = 2; cfg_frames = 1; cfg_estep = 1; cfg_fstep = 0;
      clear_stat();
      irq_mask = 16'h0;
      pulse_start();
      run_idle(n);
      check("R2 masked status", status, 0);
      irq_mask = 16'hFFFF;
      pulse_start();
      run_idle(n);
      check("R2 sticky after run", status[5], 1);
      clear_stat();
      check("R2 read clear", status, 0);

      // R4 R11 element-synchronised
      cfg_sync = 1; cfg_elems = 3; cfg_frames = 1;
      pulse_start();
      check("R4 waits for request", ch_active, 0);
      pulse_req();
      check("R11 sync bit while active", status[6], 1);
      count_for(4, n);
      check("R4 one element per request", n, 1);
      check("R11 sync bit after pause", status[6], 0);
      pulse_req(); count_for(3, n);
      pulse_req(); count_for(3, m);
      check("R4 block after three requests", n + m, 2);
      check("R4 disabled at end", ch_enabled, 0);

      // R5 frame-synchronised, held and dropped requests
      clear_stat();
      cfg_fs = 1; cfg_elems = 4; cfg_frames = 2;
      pulse_start();
      req = 1'b1;
      n = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (xfer_stb) n++;
      end
      req = 1'b0;
      @(negedge clk);
      run_idle(m);
      check("R5 held request runs second frame", n + m, 8);
      check("R5 drop bit", status[1], 1);

      // R6 packet mode, destination-synchronised
      clear_stat();
      cfg_bs = 1; cfg_pkt = 2; cfg_elems = 4; cfg_frames = 1; cfg_src_sync = 0;
      pulse_start();
      pulse_req(); count_for(6, n);
      check("R6 packet length", n, 2);
      check("R6 packet end bit", status[7], 1);
      pulse_req(); count_for(6, n);
      check("R6 second packet ends block", ch_enabled, 0);
      // R6 source-synchronised: no packet end bit
      clear_stat();
      cfg_src_sync = 1;
      pulse_start();
      pulse_req(); count_for(6, n);
      check("R6 src sync no packet bit", status[7], 0);
      pulse_req(); count_for(6, n);
      cfg_src_sync = 0; cfg_sync = 0; cfg_fs = 0; cfg_bs = 0;

      // R8 link hand-over
      cfg_link_en = 1; cfg_link_ch = 4'd5; cfg_elems = 2; cfg_frames = 1;
      pulse_start();
      seen = 0; lc = 0; en_at = 1;
      for (int i = 0; i < 6; i++) begin
         if (link_stb) begin seen = 1; lc = link_ch; en_at = ch_enabled; end
         @(negedge clk);
      end
      check("R8 link pulse", seen, 1);
      check("R8 link channel", lc, 5);
      check("R8 disabled with link", en_at, 0);
      cfg_link_en = 0;

      // R9 auto-init park and resume, then repeat
      cfg_chain_mode = 0; cfg_autoinit = 1;
      pulse_start();
      count_for(6, n);
      check("R9 parked after block", n, 2);
      check("R9 parked stays enabled", {ch_enabled, ch_active}, 2'b10);
      resume = 1'b1; @(negedge clk); resume = 1'b0;
      count_for(5, n);
      check("R9 resume restarts block", n, 2);
      cfg_repeat = 1;
      resume = 1'b1; @(negedge clk); resume = 1'b0;
      count_for(6, n);
      check("R9 repeat keeps running", n, 6);
      cfg_autoinit = 0; cfg_repeat = 0;
      run_idle(n);
      check("R9 no auto-init disables", ch_enabled, 0);

      // R10 constant fill and transparent copy
      cfg_chain_mode = 1; cfg_elems = 1; cfg_color = 32'hA5A5_5A5A;
      cfg_const_fill = 1; rd_data = 32'h0;
      pulse_start();
      check("R10 fill data", wr_data, 32'hA5A5_5A5A);
      check("R10 fill writes", wr_en, 1);
      run_idle(n);
      cfg_const_fill = 0; cfg_transp = 1; rd_data = 32'hA5A5_5A5A;
      pulse_start();
      check("R10 transparent strobe", xfer_stb, 1);
      check("R10 transparent skip", wr_en, 0);
      run_idle(n);
      rd_data = 32'h1234_5678;
      pulse_start();
      check("R10 transparent pass", {wr_en, wr_data}, {1'b1, 32'h1234_5678});
      run_idle(n);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule